// File: doc/BRIEF.md
# Interrupt Controller with Halt Wake

This block gathers interrupt requests for one processor. There are 32 numbered request lines, and each peripheral drives a single-cycle pulse on its own line. Software reaches three registers over a simple 32-bit register bus:

- a global gate (one bit);
- a per-line enable mask;
- a per-line pending set.

A pulse is recorded only on a line whose enable bit is already set. Software acknowledges a pending bit by writing a one to it.

Two signals go toward the core:

- **`irq`** is a level that asks for exception entry.
- **`wake`** releases a core that sits in a halted state.

Wake is computed apart from delivery. A per-instance parameter decides whether wake also needs the global gate. With the gate required, a halted core stays asleep while interrupts are globally off. Without it, any enabled pending line rouses the core, which then takes an interrupt only if the gate is on.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, the gate, the enable mask and the pending set all read as zero, and `irq` and `wake` are low.
- R2: The gate register at byte offset 0x0 keeps only data bit 0. A read returns that bit in bit 0 and zeros in bits 31..1.
- R3: A pulse on line n sets pending bit n at the next clock edge only if enable bit n held 1 before that edge. Otherwise the pulse is discarded and leaves no trace. This includes the cycle in which the enable bit itself is being written.
- R4: A write to the pending register at offset 0xC clears each pending bit whose data bit is 1 and keeps each bit whose data bit is 0.
- R5: `irq` is high exactly when gate bit 0 is 1 and at least one line is both pending and enabled.
- R6: `wake` is high when at least one line is both pending and enabled. With `WAKE_NEEDS_MASTER`=1 it additionally needs gate bit 0 to be 1; with 0 the gate is ignored.
- R7: When a request pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R8: Offsets other than 0x0, 0x8 (enable) and 0xC (pending) read as zero, and writes to them change no register.
- R9: Writing the enable mask at offset 0x8 leaves the pending set untouched. A masked pending bit stops driving `irq`/`wake` and drives them again once re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_LINES | Single-cycle request pulses, one bit per line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request level toward the core |
| wake | output | 1 | Halt release toward the core |

## Verification
The assertions take three things for granted about the inputs:

- reset is held from time zero until after the first clock edge;
- request lines carry one-cycle pulses;
- bus offsets are word aligned, so only the three decoded offsets or harmless unmapped ones appear.

The stimulus changes every input only on falling clock edges and returns the request lines and the write strobe to zero after one cycle. Two instances share the same stimulus so that both wake policies are exercised under identical register contents.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

    // Byte offsets of the three registers on the register bus
    localparam int OFS_GATE    = 'h0;
    localparam int OFS_ENABLE  = 'h8;
    localparam int OFS_PENDING = 'hC;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_GATE    = 2'd1,
        SEL_ENABLE  = 2'd2,
        SEL_PENDING = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_wake_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == ADDR_W'(OFS_GATE))
            sel = SEL_GATE;
        else if (addr == ADDR_W'(OFS_ENABLE))
            sel = SEL_ENABLE;
        else if (addr == ADDR_W'(OFS_PENDING))
            sel = SEL_PENDING;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_wake_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic                 wr,
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 gate_q_o,
    output logic [NUM_LINES-1:0] en_q_o,
    output logic [NUM_LINES-1:0] pend_q_o
);

    typedef struct packed {
        logic                 gate;
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] pend;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_LINES-1:0] clr_d;
    logic [NUM_LINES-1:0] set_d;

    always_comb begin
        regs_d = regs_q;

        // Clear mask from a pending write; new requests are gated by the
        // enable value held before this edge and take priority over clears
        clr_d = (wr && sel == SEL_PENDING) ? wdata[NUM_LINES-1:0] : '0;
        set_d = req & regs_q.en;
        regs_d.pend = (regs_q.pend & ~clr_d) | set_d;

        if (wr && sel == SEL_GATE)
            regs_d.gate = wdata[0];
        if (wr && sel == SEL_ENABLE)
            regs_d.en = wdata[NUM_LINES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        unique case (sel)
            SEL_GATE:    rdata = DATA_W'(regs_q.gate);
            SEL_ENABLE:  rdata = DATA_W'(regs_q.en);
            SEL_PENDING: rdata = DATA_W'(regs_q.pend);
            default:     rdata = '0;
        endcase
    end

    assign gate_q_o = regs_q.gate;
    assign en_q_o   = regs_q.en;
    assign pend_q_o = regs_q.pend;

endmodule

// File: rtl/irq_out_logic.sv
module irq_out_logic #(
    parameter int NUM_LINES         = 32,
    parameter bit WAKE_NEEDS_MASTER = 1'b1
) (
    input  logic                 gate,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] pend,
    output logic                 irq,
    output logic                 wake
);

    logic live;

    assign live = |(pend & en);
    assign irq  = gate & live;

    generate
        if (WAKE_NEEDS_MASTER) begin : g_wake_gated
            assign wake = gate & live;
        end else begin : g_wake_free
            assign wake = live;
        end
    endgenerate

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int NUM_LINES         = 32,
    parameter int DATA_W            = 32,
    parameter int ADDR_W            = 4,
    parameter bit WAKE_NEEDS_MASTER = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq,
    output logic                 wake
);

    reg_sel_e             reg_sel;
    logic                 gate_en;
    logic [NUM_LINES-1:0] en_mask;
    logic [NUM_LINES-1:0] pend_vec;

    irq_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (reg_sel)
    );

    irq_reg_bank #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .wr       (bus_wr),
        .sel      (reg_sel),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .gate_q_o (gate_en),
        .en_q_o   (en_mask),
        .pend_q_o (pend_vec)
    );

    irq_out_logic #(
        .NUM_LINES         (NUM_LINES),
        .WAKE_NEEDS_MASTER (WAKE_NEEDS_MASTER)
    ) u_out (
        .gate (gate_en),
        .en   (en_mask),
        .pend (pend_vec),
        .irq  (irq),
        .wake (wake)
    );

endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk
    import irq_wake_pkg::*;
#(
    parameter int NUM_LINES         = 32,
    parameter int ADDR_W            = 4,
    parameter bit WAKE_NEEDS_MASTER = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] req,
    input logic                 wr,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_LINES-1:0] wdata,
    input logic                 irq,
    input logic                 wake,
    input logic                 gate,
    input logic [NUM_LINES-1:0] en,
    input logic [NUM_LINES-1:0] pend
);

    logic [NUM_LINES-1:0] accepted;
    logic                 pend_wr;

    assign accepted = req & en;
    assign pend_wr  = wr && (addr == ADDR_W'(OFS_PENDING));

    AST_IRQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gate);  // R5

    AST_IRQ_HAS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake);  // R6

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|accepted) |=> ((pend & $past(accepted)) == $past(accepted)));  // R7

    AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(accepted)) == '0));  // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(wdata & ~accepted)) == '0));  // R4

    generate
        if (WAKE_NEEDS_MASTER) begin : g_chk_gated
            AST_WAKE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
                wake |-> gate);  // R6
        end
    endgenerate

endmodule

bind irq_wake_ctrl irq_wake_chk #(
    .NUM_LINES         (NUM_LINES),
    .ADDR_W            (ADDR_W),
    .WAKE_NEEDS_MASTER (WAKE_NEEDS_MASTER)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata[NUM_LINES-1:0]),
    .irq   (irq),
    .wake  (wake),
    .gate  (gate_en),
    .en    (en_mask),
    .pend  (pend_vec)
);

// File: tb/irq_wake_ctrl_tb.sv
`timescale 1ns/1ps
module irq_wake_ctrl_tb;

    localparam logic [3:0] A_GATE = 4'h0;
    localparam logic [3:0] A_EN   = 4'h8;
    localparam logic [3:0] A_PEND = 4'hC;
    localparam logic [3:0] A_HOLE = 4'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_alt;
    logic        irq, wake, irq_alt, wake_alt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model of the register contents, built from the requirements
    logic        m_gate = 1'b0;
    logic [31:0] m_en = '0;
    logic [31:0] m_pend = '0;

    always #5 clk = ~clk;

    irq_wake_ctrl #(.WAKE_NEEDS_MASTER(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake));

    irq_wake_ctrl #(.WAKE_NEEDS_MASTER(1'b0)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_alt),
        .irq(irq_alt), .wake(wake_alt));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // One bus/request cycle driven on a falling edge, model updated per R3/R4/R7
    task automatic drive(input logic wr, input logic [3:0] a,
                         input logic [31:0] d, input logic [31:0] r);
        logic [31:0] clr;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; irq_req = r;
        clr = (wr && a == A_PEND) ? d : '0;
        m_pend = (m_pend & ~clr) | (r & m_en);
        if (wr && a == A_GATE) m_gate = d[0];
        if (wr && a == A_EN)   m_en = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; irq_req = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic check_outputs(input string req);
        logic live;
        live = |(m_pend & m_en);
        check(req, "irq", {31'b0, irq}, {31'b0, m_gate & live});
        check(req, "wake gated", {31'b0, wake}, {31'b0, m_gate & live});
        check(req, "wake free", {31'b0, wake_alt}, {31'b0, live});
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        rd(A_GATE, v); check(req, "gate reg", v, {31'b0, m_gate});
        rd(A_EN, v);   check(req, "enable reg", v, m_en);
        rd(A_PEND, v); check(req, "pending reg", v, m_pend);
    endtask

    task automatic t_reset();
        check_regs("R1");
        check_outputs("R1");
    endtask

    task automatic t_gate_bits();
        logic [31:0] v;
        drive(1'b1, A_GATE, 32'hFFFF_FFFF, '0);
        rd(A_GATE, v); check("R2", "gate all ones", v, 32'h1);
        drive(1'b1, A_GATE, 32'hFFFF_FFFE, '0);
        rd(A_GATE, v); check("R2", "gate bit0 clear", v, 32'h0);
    endtask

    task automatic t_drop_disabled();
        logic [31:0] v;
        drive(1'b0, A_GATE, '0, 32'h0000_0020);
        drive(1'b1, A_EN, 32'h0000_0020, '0);
        rd(A_PEND, v); check("R3", "disabled pulse dropped", v, 32'h0);
        // enable written in the same cycle as the pulse: still dropped
        drive(1'b1, A_EN, 32'h0000_00A0, 32'h0000_0080);
        rd(A_PEND, v); check("R3", "same-cycle enable", v, 32'h0);
        check_outputs("R6");
    endtask

    task automatic t_latch_and_wake();
        logic [31:0] v;
        drive(1'b1, A_EN, 32'h0000_0021, '0);
        drive(1'b0, A_GATE, '0, 32'h0000_0023);
        rd(A_PEND, v); check("R3", "enabled lines latched", v, 32'h0000_0021);
        check_outputs("R6");     // gate off: only the free-wake instance wakes
        check("R6", "free wake gate off", {31'b0, wake_alt}, 32'h1);
        check("R5", "irq gate off", {31'b0, irq}, 32'h0);
        drive(1'b1, A_GATE, 32'h1, '0);
        check_outputs("R5");
        check("R5", "irq gate on", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        drive(1'b1, A_PEND, 32'h0000_0001, '0);
        check_regs("R4");
        check("R4", "one bit left", m_pend, 32'h0000_0020);
        check_outputs("R4");
        drive(1'b1, A_PEND, 32'hFFFF_FFDF, '0);
        check_regs("R4");
        drive(1'b1, A_PEND, 32'h0000_0020, '0);
        check_regs("R4");
        check_outputs("R5");
    endtask

    task automatic t_race();
        logic [31:0] v;
        drive(1'b0, A_GATE, '0, 32'h0000_0001);
        drive(1'b1, A_PEND, 32'h0000_0001, 32'h0000_0001);
        rd(A_PEND, v); check("R7", "request beats clear", v, 32'h0000_0001);
        drive(1'b1, A_PEND, 32'h0000_0001, 32'h0000_0020);
        rd(A_PEND, v); check("R7", "other bit cleared", v, 32'h0000_0020);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        drive(1'b1, A_EN, 32'h0000_0001, '0);
        rd(A_PEND, v); check("R9", "pending kept on mask", v, 32'h0000_0020);
        check_outputs("R9");
        check("R9", "irq masked", {31'b0, irq}, 32'h0);
        drive(1'b1, A_EN, 32'h0000_0021, '0);
        check_outputs("R9");
        check("R9", "irq restored", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        drive(1'b1, A_HOLE, 32'hFFFF_FFFF, '0);
        rd(A_HOLE, v); check("R8", "hole reads zero", v, 32'h0);
        drive(1'b1, 4'h1, 32'h0000_0000, '0);
        check_regs("R8");
        check_outputs("R8");
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_bits();
        t_drop_disabled();
        t_latch_and_wake();
        t_clear();
        t_race();
        t_mask();
        t_unmapped();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule